// File: doc/BRIEF.md
# In-Order Pipeline Control with Register Busy Bits

This block sequences instructions through three single-cycle-per-step stages (fetch, decode, execute) and adds a one-cycle writeback register behind execute. Each instruction names a destination register, two source registers, a small immediate and an execute latency of 1 to 4 cycles. The execute step adds the two source values and the immediate. A behavioural register file holds one data word and one ready bit per register.

When an instruction leaves decode for execute, the ready bit of its destination is dropped. An instruction in decode waits there while either source, or its own destination, is not ready. A result arriving on the writeback path in the same cycle counts as ready. The wait ripples backward. Decode blocks fetch, and a blocked fetch drops the ready of the input stream. Results are written back and retired strictly in the order instructions were accepted.

The input is a valid/ready stream. A word transfers on a clock edge where both `in_valid` and `in_ready` are high. The source may hold `in_valid` high for as long as it likes. `in_ready` does not depend on `in_valid`. The writeback output is a one-cycle pulse and cannot be back-pressured. A combinational peek port shows the stored value and ready bit of any register.

Top module: `sbp_pipe`

## Requirements
- R1: After reset, every register reads value 0 with its ready bit set, `in_ready` is 1 and `wb_valid` is 0.
- R2: An input word is taken only on an edge where `in_valid` and `in_ready` are both high. The fields it carries reach execute unchanged.
- R3: Each instruction produces `reg[src_a] + reg[src_b] + imm`, taken modulo 2^16 with the immediate zero-extended. The result appears as a one-cycle `wb_valid` pulse with `wb_idx` = destination, in acceptance order. It is stored in the register on the following edge.
- R4: `in_lat` holds the latency minus one (0 to 3 give 1 to 4 cycles). With no hazard between them, the writeback pulses of two back-to-back instructions are spaced by the latency of the later one.
- R5: An instruction that moves from decode to execute drops the ready bit of its destination register.
- R6: An instruction stays in decode, unchanged, while a source register is not ready. A writeback of that register in the current cycle releases it. A dependent instruction therefore writes back (its latency + 1) cycles after its producer.
- R7: An instruction also stays in decode while its destination is not ready. When it leaves in the same cycle as an older write to that register, the drop of the ready bit overrides the write's set, and the register stays not ready.
- R8: A held decode keeps the next instruction in fetch, and `in_ready` is 0 while fetch is held. With an empty pipe, a latency-4 producer A, a dependent B and two more words C and D sent back to back, C is taken 2 edges after A and D is taken 7 edges after A.
- R9: Register 0 always reads 0 and is always ready. Writes to it are discarded, and naming it never causes a wait.
- R10: A writeback sets the register's ready bit, and the value becomes visible on the peek port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Fetch can take a word this cycle |
| in_dst | input | 3 | Destination register index |
| in_src_a | input | 3 | First source register index |
| in_src_b | input | 3 | Second source register index |
| in_imm | input | 8 | Immediate added to the sum |
| in_lat | input | 2 | Execute latency minus one |
| wb_valid | output | 1 | Writeback pulse |
| wb_idx | output | 3 | Register being written |
| wb_data | output | 16 | Value being written |
| rd_idx | input | 3 | Peek register index |
| rd_data | output | 16 | Stored value of the peeked register |
| rd_valid | output | 1 | Ready bit of the peeked register |

## Verification
The bench sends independent words at latencies 1 and 3 to measure plain pulse spacing. It then sends read-after-write chains, where the extra cycle of spacing shows that decode waited for the bypassed writeback. A write-after-write pair checks that the younger instruction's drop of the ready bit beats the older one's write. A long-latency producer followed by three words shows that the wait reaches the input handshake at the expected edges. Finally, a writer to register 0 followed by a reader of it must show no wait at all.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  parameter int NREG    = 8;
  parameter int DATA_W  = 16;
  parameter int IMM_W   = 8;
  parameter int MAX_LAT = 4;
  localparam int IDX_W  = $clog2(NREG);
  localparam int LAT_W  = $clog2(MAX_LAT);
  localparam int CNT_W  = $clog2(MAX_LAT + 1);

  typedef struct packed {
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] sa;
    logic [IDX_W-1:0] sb;
    logic [IMM_W-1:0] imm;
    logic [LAT_W-1:0] lat;
  } instr_t;
endpackage

// File: rtl/sbp_regfile.sv
module sbp_regfile
  import sbp_pkg::*;
#(
  parameter int NLK = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  lk_idx  [NLK],
  output logic              lk_ok   [NLK],
  output logic [DATA_W-1:0] lk_data [NLK],
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [NREG-1:0]   ok_vec
);
  logic [DATA_W-1:0] mem [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    if (gi == 0) begin : g_zero
      assign mem[gi]    = '0;
      assign ok_vec[gi] = 1'b1;
    end else begin : g_live
      logic [DATA_W-1:0] val_q;
      logic              ok_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          val_q <= '0;
          ok_q  <= 1'b1;
        end else begin
          if (wr_en && wr_idx == IDX_W'(gi)) begin
            val_q <= wr_data;
            ok_q  <= 1'b1;
          end
          // a younger instruction's clear overrides an older write
          if (clr_en && clr_idx == IDX_W'(gi)) ok_q <= 1'b0;
        end
      end
      assign mem[gi]    = val_q;
      assign ok_vec[gi] = ok_q;
    end
  end

  for (genvar li = 0; li < NLK; li++) begin : g_lk
    logic hit;
    assign hit         = wr_en && (wr_idx == lk_idx[li]) && (lk_idx[li] != '0);
    assign lk_ok[li]   = ok_vec[lk_idx[li]] || hit;
    assign lk_data[li] = hit ? wr_data : mem[lk_idx[li]];
  end

  assign rd_data  = mem[rd_idx];
  assign rd_valid = ok_vec[rd_idx];
endmodule

// File: rtl/sbp_exec.sv
module sbp_exec
  import sbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [IDX_W-1:0]  dst,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  input  logic [LAT_W-1:0]  lat,
  output logic              free,
  output logic              done,
  output logic [IDX_W-1:0]  done_dst,
  output logic [DATA_W-1:0] done_data
);
  logic              vld_q;
  logic [CNT_W-1:0]  rem_q;
  logic [IDX_W-1:0]  dst_q;
  logic [DATA_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rem_q <= '0;
      dst_q <= '0;
      res_q <= '0;
    end else if (go) begin
      vld_q <= 1'b1;
      rem_q <= CNT_W'(lat) + CNT_W'(1);
      dst_q <= dst;
      res_q <= opa + opb + DATA_W'(imm);
    end else if (done) begin
      vld_q <= 1'b0;
    end else if (vld_q) begin
      rem_q <= rem_q - CNT_W'(1);
    end
  end

  assign done      = vld_q && (rem_q == CNT_W'(1));
  assign free      = !vld_q || done;
  assign done_dst  = dst_q;
  assign done_data = res_q;
endmodule

// File: rtl/sbp_pipe.sv
module sbp_pipe
  import sbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_dst,
  input  logic [IDX_W-1:0]  in_src_a,
  input  logic [IDX_W-1:0]  in_src_b,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [LAT_W-1:0]  in_lat,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int NLK = 3;

  logic              f_vld, d_vld, f_go, d_go;
  instr_t            f_ins, d_ins;
  logic              w_vld;
  logic [IDX_W-1:0]  w_dst;
  logic [DATA_W-1:0] w_data;
  logic              e_free, e_done;
  logic [IDX_W-1:0]  e_dst;
  logic [DATA_W-1:0] e_data;
  logic [IDX_W-1:0]  lk_idx  [NLK];
  logic              lk_ok   [NLK];
  logic [DATA_W-1:0] lk_data [NLK];
  logic [NREG-1:0]   sb_ok;
  logic              all_ok;

  assign lk_idx[0] = d_ins.sa;
  assign lk_idx[1] = d_ins.sb;
  assign lk_idx[2] = d_ins.dst;

  always_comb begin
    all_ok = 1'b1;
    for (int i = 0; i < NLK; i++) all_ok = all_ok && lk_ok[i];
  end

  assign d_go     = d_vld && all_ok && e_free;
  assign f_go     = f_vld && (!d_vld || d_go);
  assign in_ready = !f_vld || f_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_vld <= 1'b0;
      f_ins <= '0;
    end else if (in_valid && in_ready) begin
      f_vld <= 1'b1;
      f_ins <= '{dst: in_dst, sa: in_src_a, sb: in_src_b, imm: in_imm, lat: in_lat};
    end else if (f_go) begin
      f_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_vld <= 1'b0;
      d_ins <= '0;
    end else if (f_go) begin
      d_vld <= 1'b1;
      d_ins <= f_ins;
    end else if (d_go) begin
      d_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_vld  <= 1'b0;
      w_dst  <= '0;
      w_data <= '0;
    end else begin
      w_vld <= e_done;
      if (e_done) begin
        w_dst  <= e_dst;
        w_data <= e_data;
      end
    end
  end

  sbp_exec exec_i (
    .clk(clk), .rst_n(rst_n), .go(d_go), .dst(d_ins.dst),
    .opa(lk_data[0]), .opb(lk_data[1]), .imm(d_ins.imm), .lat(d_ins.lat),
    .free(e_free), .done(e_done), .done_dst(e_dst), .done_data(e_data)
  );

  sbp_regfile #(.NLK(NLK)) rf_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(w_vld), .wr_idx(w_dst), .wr_data(w_data),
    .clr_en(d_go && d_ins.dst != '0), .clr_idx(d_ins.dst),
    .lk_idx(lk_idx), .lk_ok(lk_ok), .lk_data(lk_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
    .ok_vec(sb_ok)
  );

  assign wb_valid = w_vld;
  assign wb_idx   = w_dst;
  assign wb_data  = w_data;
endmodule

// File: rtl/sbp_pipe_chk.sv
module sbp_pipe_chk
  import sbp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             f_vld,
  input logic             f_go,
  input instr_t           f_ins,
  input logic             d_vld,
  input logic             d_go,
  input instr_t           d_ins,
  input logic             wb_valid,
  input logic [IDX_W-1:0] wb_idx,
  input logic [NREG-1:0]  ok_vec
);
  AST_ZERO_REG_READY: assert property (@(posedge clk) disable iff (!rst_n) ok_vec[0]); // R9
  AST_CLEAR_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    d_go && d_ins.dst != '0 |=> !ok_vec[$past(d_ins.dst)]); // R5
  AST_CLEAR_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    d_go && wb_valid && d_ins.dst == wb_idx && wb_idx != '0 |=> !ok_vec[$past(wb_idx)]); // R7
  AST_WRITE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_idx != '0 && !(d_go && d_ins.dst == wb_idx) |=> ok_vec[$past(wb_idx)]); // R10
  AST_SOURCES_READY_AT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    d_go |-> (ok_vec[d_ins.sa] || (wb_valid && wb_idx == d_ins.sa))
          && (ok_vec[d_ins.sb] || (wb_valid && wb_idx == d_ins.sb))); // R6
  AST_DECODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    d_vld && !d_go |=> d_vld && $stable(d_ins)); // R6
  AST_FETCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    f_vld && !f_go |=> f_vld && $stable(f_ins)); // R8
  AST_NO_INTAKE_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    f_vld && !f_go |-> !in_ready); // R8
endmodule

bind sbp_pipe sbp_pipe_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .f_vld(f_vld), .f_go(f_go), .f_ins(f_ins),
  .d_vld(d_vld), .d_go(d_go), .d_ins(d_ins),
  .wb_valid(wb_valid), .wb_idx(wb_idx), .ok_vec(sb_ok)
);

// File: tb/sbp_pipe_tb_top.sv
module sbp_pipe_tb_top;
  import sbp_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IDX_W-1:0]  in_dst = '0, in_src_a = '0, in_src_b = '0, rd_idx = '0;
  logic [IMM_W-1:0]  in_imm = '0;
  logic [LAT_W-1:0]  in_lat = '0;
  logic              wb_valid, rd_valid;
  logic [IDX_W-1:0]  wb_idx;
  logic [DATA_W-1:0] wb_data, rd_data;

  always #10 clk = ~clk;

  sbp_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_imm(in_imm), .in_lat(in_lat),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  typedef struct {
    int  idx;
    int  data;
    int  gap;
    bit  busy_chk;
  } exp_t;

  exp_t q[$];
  int   mdl [NREG];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   live = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic peek(input int idx, input int exp_v, input int exp_d,
                      input bit use_d, input string req);
    rd_idx = IDX_W'(idx);
    #1;
    chk(rd_valid == exp_v[0], req, $sformatf("ready bit r%0d", idx), rd_valid, exp_v);
    if (use_d) chk(int'(rd_data) == exp_d, req, $sformatf("value r%0d", idx), rd_data, exp_d);
  endtask

  // driver: offers one word, records the accepting edge, pushes the expected result
  task automatic send(input int dst, input int sa, input int sb, input int imm,
                      input int lat, input int gap, input bit bchk, output int acc);
    int v;
    @(negedge clk);
    in_valid = 1'b1;
    in_dst = IDX_W'(dst); in_src_a = IDX_W'(sa); in_src_b = IDX_W'(sb);
    in_imm = IMM_W'(imm); in_lat = LAT_W'(lat - 1);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc + 1;
    v = (mdl[sa] + mdl[sb] + imm) & 32'hFFFF;
    if (dst != 0) mdl[dst] = v;
    q.push_back('{idx: dst, data: v, gap: gap, busy_chk: bchk});
    @(posedge clk);
  endtask

  task automatic idle_drain();
    @(negedge clk);
    in_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // monitor: pops expected writebacks in order and compares data and spacing
  initial begin
    int last = 0;
    bit pend = 1'b0;
    int pend_idx = 0;
    forever begin
      @(negedge clk);
      if (pend) begin
        pend = 1'b0;
        peek(pend_idx, 0, 0, 1'b0, "R7"); // clear beat the same-edge write
      end
      if (live && wb_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3", "unexpected writeback idx", wb_idx, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(int'(wb_idx) == e.idx, "R3", "writeback index", wb_idx, e.idx);
          chk(int'(wb_data) == e.data, "R3", "writeback data", wb_data, e.data);
          if (e.gap >= 0) chk(cyc - last == e.gap, "R4/R6", "writeback spacing", cyc - last, e.gap);
          if (e.busy_chk) begin
            pend = 1'b1;
            pend_idx = e.idx;
          end
        end
        last = cyc;
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ca, cb, cc, cd;
    for (int i = 0; i < NREG; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(wb_valid == 1'b0, "R1", "wb_valid after reset", wb_valid, 0);
    peek(4, 1, 0, 1'b1, "R1");
    peek(7, 1, 0, 1'b1, "R1");
    live = 1'b1;

    // R2 R3 R4: independent words, latencies 1, 1, 3
    send(1, 0, 0, 5, 1, -1, 1'b0, ca);
    send(2, 0, 0, 7, 1, 1, 1'b0, ca);
    send(3, 0, 0, 9, 3, 3, 1'b0, ca);
    // R6: r4 reads settled registers, r5 reads the fresh r4
    send(4, 1, 2, 1, 1, 1, 1'b0, ca);
    send(5, 4, 3, 0, 2, 3, 1'b0, ca);
    idle_drain();

    // R8: latency-4 producer, dependent, then two more words back to back
    send(6, 5, 0, 2, 4, -1, 1'b0, ca);
    send(7, 6, 6, 0, 1, 2, 1'b0, cb);
    send(1, 7, 0, 1, 1, 2, 1'b0, cc);
    send(2, 0, 0, 3, 1, 1, 1'b0, cd);
    chk(cb - ca == 1, "R8", "second word intake edge", cb - ca, 1);
    chk(cc - ca == 2, "R8", "third word intake edge", cc - ca, 2);
    chk(cd - ca == 7, "R8", "fourth word intake edge", cd - ca, 7);
    @(negedge clk);
    in_valid = 1'b0;
    peek(7, 0, 0, 1'b0, "R5"); // r7 just issued, not yet written
    idle_drain();

    // R7: write-after-write on r3, then a reader of r3
    send(3, 0, 0, 11, 1, -1, 1'b1, ca);
    send(3, 0, 0, 22, 4, 5, 1'b0, ca);
    send(4, 3, 0, 1, 1, 2, 1'b0, ca);
    idle_drain();

    // R9: writer of r0 then a reader of r0, no wait expected
    send(0, 0, 0, 50, 4, -1, 1'b0, ca);
    send(5, 0, 0, 1, 1, 1, 1'b0, ca);
    idle_drain();

    peek(0, 1, 0, 1'b1, "R9");
    peek(5, 1, 1, 1'b1, "R10");
    peek(3, 1, 22, 1'b1, "R10");
    peek(1, 1, 49, 1'b1, "R10");
    peek(4, 1, 23, 1'b1, "R10");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule